// File: doc/BRIEF.md
# Real-time clock interrupt status unit

This unit collects the event strobes produced by a real-time clock's counters (second, minute, hour and day roll-overs plus a time-of-day alarm match) and turns them into interrupt requests. Each event is captured in a sticky status bit, but only while the matching enable bit of the clock's control word is on. A further status bit records that a counter load has finished; it is captured without any enable and never requests an interrupt.

A source is pending when its status bit and its enable bit are both on. The enable bits sit in the control word one position above the status bit they gate, so control bit 1 gates status bit 0, and so on up to control bit 5 gating status bit 4. Every source drives a pulse output that goes high for exactly one cycle when it becomes pending; the alarm source also drives a level output that follows its pending state. Software reads the status word and clears bits by writing ones to them.

The number of timed sources and the pulse output stage (taken straight from the pending state or delayed by one register) are parameters.

Top module: `rtc_irq_status`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe seen, the status word is all zeros, every pulse output is low and the alarm level output is low.
- R2: A strobe on event input bit i (0 second, 1 minute, 2 hour, 3 day, 4 alarm) while control bit i+1 is high sets status bit i, visible from the clock edge that samples the strobe.
- R3: A strobe on event input bit i while control bit i+1 is low leaves status bit i at zero.
- R4: A strobe on the load-done input sets status bit 5 regardless of the control word, and never causes a pulse or the alarm level output.
- R5: A clear write sets to zero every status bit whose clear data bit is one and leaves every other status bit unchanged.
- R6: When a set strobe and a clear write reach the same status bit in one cycle, the bit ends up set.
- R7: Pulse output bit i is high for exactly one cycle when source i becomes pending (control bit i+1 and status bit i both high), and stays low while it remains pending.
- R8: The alarm level output is high exactly while control bit 5 and status bit 4 are both high.
- R9: A status bit stays set until cleared, also when its enable is later dropped; dropping the enable removes the pending state, and raising it again makes the source pending anew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Per-source set strobes (bit 0 second, 1 minute, 2 hour, 3 day, 4 alarm) |
| ld_done_i | input | 1 | Counter-load-finished strobe, sets status bit 5 |
| ctrl_i | input | NUM_SRC (bits NUM_SRC..1) | Enable bits of the control word; bit i+1 gates source i |
| clr_we_i | input | 1 | Clear write strobe for the status word |
| clr_data_i | input | NUM_SRC+1 | Write-one-to-clear mask |
| status_o | output | NUM_SRC+1 | Sticky status word |
| alarm_lvl_o | output | 1 | Alarm pending, level |
| pulse_o | output | NUM_SRC | One-cycle pulse per source on becoming pending |

## Verification
The two functions that can fall in the same cycle are the capture of an event strobe and a software clear of the same status bit. The bench provokes this by asserting every pattern of event strobes together with a clear write of all ones, and separately the load-done strobe with a clear, and judges that each strobed bit reads as set afterwards while the rest read as zero, and that the pulse for each strobed source still fires. Exhaustive sweeps over every enable pattern against every strobe pattern, and every clear mask against a full status word, cover the remaining combinations.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int unsigned SRC_COUNT = 5;
   localparam int unsigned SRC_SEC   = 0;
   localparam int unsigned SRC_MIN   = 1;
   localparam int unsigned SRC_HOUR  = 2;
   localparam int unsigned SRC_DAY   = 3;
   localparam int unsigned SRC_ALARM = 4;

   typedef enum logic [0:0] {
      PULSE_COMB = 1'b0,
      PULSE_REG  = 1'b1
   } pulse_mode_e;
endpackage

// File: rtl/rtc_irq_stick_cell.sv
module rtc_irq_stick_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic en_i,
   input  logic clr_i,
   output logic q_o
);
   logic take;
   logic nxt;

   assign take = set_i & en_i;
   assign nxt  = take | (q_o & ~clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= nxt;
   end

   // R2
   set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && en_i) |=> q_o);

   // R6
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && en_i && clr_i) |=> q_o);

   // R5
   clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(set_i && en_i) && clr_i) |=> !q_o);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(set_i && en_i) && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/rtc_irq_edge_gen.sv
module rtc_irq_edge_gen #(
   parameter rtc_irq_pkg::pulse_mode_e MODE = rtc_irq_pkg::PULSE_COMB
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic pulse_o
);
   logic lvl_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise = lvl_i & ~lvl_q;

   generate
      if (MODE == rtc_irq_pkg::PULSE_REG) begin : g_reg
         logic rise_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q <= 1'b0;
            else        rise_q <= rise;
         end
         assign pulse_o = rise_q;
      end else begin : g_comb
         assign pulse_o = rise;
      end
   endgenerate

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
   parameter int unsigned              NUM_SRC    = rtc_irq_pkg::SRC_COUNT,
   parameter rtc_irq_pkg::pulse_mode_e PULSE_MODE = rtc_irq_pkg::PULSE_COMB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               ld_done_i,
   input  logic [NUM_SRC:1]   ctrl_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC:0]   clr_data_i,
   output logic [NUM_SRC:0]   status_o,
   output logic               alarm_lvl_o,
   output logic [NUM_SRC-1:0] pulse_o
);
   localparam int unsigned ALARM_IDX = NUM_SRC - 1;
   localparam int unsigned LD_IDX    = NUM_SRC;

   generate
      if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_cfg
         $error("rtc_irq_status: NUM_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         rtc_irq_stick_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_i[i]),
            .en_i  (ctrl_i[i+1]),
            .clr_i (clr_we_i & clr_data_i[i]),
            .q_o   (status_o[i])
         );

         assign pend[i] = ctrl_i[i+1] & status_o[i];

         rtc_irq_edge_gen #(.MODE(PULSE_MODE)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (pend[i]),
            .pulse_o (pulse_o[i])
         );
      end
   endgenerate

   rtc_irq_stick_cell u_ld_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ld_done_i),
      .en_i  (1'b1),
      .clr_i (clr_we_i & clr_data_i[LD_IDX]),
      .q_o   (status_o[LD_IDX])
   );

   assign alarm_lvl_o = pend[ALARM_IDX];

   // R8
   alarm_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[ALARM_IDX] |-> !alarm_lvl_o);

   // R4
   ld_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_done_i && !clr_we_i) |=> status_o[LD_IDX]);

   // R7
   pulse_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PULSE_MODE == rtc_irq_pkg::PULSE_COMB) |-> ((pulse_o & ~status_o[NUM_SRC-1:0]) == '0));
endmodule

// File: tb/rtc_irq_status_tb_top.sv
module rtc_irq_status_tb_top;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic         ld = 1'b0;
   logic [N:1]   ctrl = '0;
   logic         clr_we = 1'b0;
   logic [N:0]   clr_data = '0;
   logic [N:0]   status;
   logic         alarm_lvl;
   logic [N-1:0] pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rtc_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ld_done_i(ld), .ctrl_i(ctrl),
      .clr_we_i(clr_we), .clr_data_i(clr_data), .status_o(status),
      .alarm_lvl_o(alarm_lvl), .pulse_o(pulse)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic clear_all();
      clr_we = 1'b1; clr_data = '1;
      tick();
      clr_we = 1'b0; clr_data = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset with strobes present
      ctrl = '1; evt = '1; ld = 1'b1;
      repeat (3) tick();
      chk("R1 status in reset", int'(status), 0);
      chk("R1 pulse in reset", int'(pulse), 0);
      chk("R1 level in reset", int'(alarm_lvl), 0);
      evt = '0; ld = 1'b0;
      rst_n = 1'b1;
      repeat (2) tick();
      chk("R1 status after reset", int'(status), 0);
      chk("R1 pulse after reset", int'(pulse), 0);
      chk("R1 level after reset", int'(alarm_lvl), 0);

      // R2 R3 R7 R8 R9: every enable pattern against every strobe pattern
      for (int en = 0; en < 32; en++) begin
         for (int s = 0; s < 32; s++) begin
            int e;
            e = s & en;
            ctrl = en[4:0]; evt = s[4:0];
            tick();
            evt = '0;
            chk("R2/R3 status after strobe", int'(status), e);
            chk("R7 pulse on becoming pending", int'(pulse), e);
            chk("R8 alarm level", int'(alarm_lvl), (e >> 4) & 1);
            tick();
            chk("R7 no second pulse", int'(pulse), 0);
            chk("R9 status held", int'(status), e);
            clear_all();
            chk("R5 clear all", int'(status), 0);
         end
      end

      // R5: every clear mask against a full status word
      ctrl = '1;
      for (int p = 0; p < 64; p++) begin
         evt = '1; ld = 1'b1;
         tick();
         evt = '0; ld = 1'b0;
         clr_we = 1'b1; clr_data = p[5:0];
         tick();
         clr_we = 1'b0; clr_data = '0;
         chk("R5 partial clear", int'(status), 63 & ~p);
         clear_all();
      end

      // R6: set and clear in the same cycle
      for (int s = 0; s < 32; s++) begin
         ctrl = '1; evt = s[4:0]; clr_we = 1'b1; clr_data = '1;
         tick();
         evt = '0; clr_we = 1'b0; clr_data = '0;
         chk("R6 set wins over clear", int'(status), s);
         chk("R6 pulse despite clear", int'(pulse), s);
         clear_all();
      end
      ld = 1'b1; clr_we = 1'b1; clr_data = '1;
      tick();
      ld = 1'b0; clr_we = 1'b0; clr_data = '0;
      chk("R6 load-done set wins over clear", int'(status), 32);
      clear_all();

      // R4: load-done with nothing enabled, then with everything enabled
      ctrl = '0; ld = 1'b1;
      tick();
      ld = 1'b0;
      chk("R4 load-done captured", int'(status), 32);
      chk("R4 no pulse", int'(pulse), 0);
      chk("R4 no level", int'(alarm_lvl), 0);
      clear_all();
      ctrl = '1; ld = 1'b1;
      tick();
      ld = 1'b0;
      chk("R4 load-done captured enabled", int'(status), 32);
      chk("R4 no pulse enabled", int'(pulse), 0);
      clear_all();

      // R9 R8: enable dropped and raised again
      ctrl = '1; evt = 5'b10000;
      tick();
      evt = '0;
      chk("R8 alarm level high", int'(alarm_lvl), 1);
      tick();
      ctrl = '0;
      #1;
      chk("R9 level drops with enable", int'(alarm_lvl), 0);
      chk("R9 status kept with enable low", int'(status), 16);
      tick();
      ctrl = '1;
      #1;
      chk("R9 pulse on re-enable", int'(pulse), 16);
      chk("R8 level on re-enable", int'(alarm_lvl), 1);
      tick();
      chk("R7 single pulse after re-enable", int'(pulse), 0);
      clear_all();
      chk("R8 level after clear", int'(alarm_lvl), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule